// File: doc/BRIEF.md
# NaN Precision Converter

This unit moves a not-a-number value between the half (16-bit), single (32-bit) and double (64-bit) binary floating-point encodings. The fraction of the incoming NaN is first placed in a 64-bit canonical field with its most significant fraction bit at bit 63. The outgoing NaN is then rebuilt from the top of that field, with the source sign kept and all exponent bits set. If narrowing leaves no payload, the destination's default NaN is produced instead. A mode input forces the default NaN for every NaN result. A polarity input selects whether a set top fraction bit marks a quiet NaN or a signaling NaN.

The result, a valid strobe and an invalid-operation flag are registered, so each accepted operand gives its answer one clock later. Operands that are not NaNs pass through untouched and raise no flag. Format-select codes outside the three supported encodings are trapped.

Top module: `nan_fmt_conv`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_invalid` is never high while `out_valid` is low. `out_value` holds its last result while no operand is accepted. Reset clears all three outputs to zero.
- R2: A source operand is a NaN when its exponent is all ones and its fraction is nonzero. With `snan_pol`=0, a NaN with the top fraction bit clear is signaling. With `snan_pol`=1, a NaN with that bit set is signaling. `out_invalid` is raised exactly for signaling NaN inputs.
- R3: Format codes on `src_fmt` and `dst_fmt` are 0 for half (operand in bits 15:0), 1 for single (bits 31:0) and 2 for double (bits 63:0). A NaN result is right-aligned in `out_value`, with the bits above its width zero.
- R4: A NaN result carries the source sign and an all-ones exponent. Its fraction is the top destination-width bits of the source fraction, left-aligned: zeros are appended when widening and low bits are dropped when narrowing. No quieting is applied.
- R5: If the fraction produced under R4 is zero, the output is the destination default NaN.
- R6: With `dflt_mode`=1, every NaN input yields the destination default NaN, and `out_invalid` still follows R2.
- R7: A legal-format operand that is not a NaN is copied to `out_value` unchanged, with `out_invalid` low.
- R8: The default NaN patterns depend on `snan_pol`. With `snan_pol`=0 they are 0xFE00 (half), 0xFFC00000 (single) and 0xFFF8000000000000 (double). With `snan_pol`=1 they are 0x7DFF, 0x7FBFFFFF and 0x7FF7FFFFFFFFFFFF.
- R9: Code 3 on either format select yields the destination default NaN and raises `out_invalid`. When `dst_fmt` is itself 3, the double default NaN is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_value | input | 64 | Operand, right-aligned for narrow formats |
| src_fmt | input | 2 | Source encoding code |
| dst_fmt | input | 2 | Destination encoding code |
| dflt_mode | input | 1 | Force default NaN for NaN results |
| snan_pol | input | 1 | 1: set top fraction bit means signaling |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_value | output | 64 | Converted value |
| out_invalid | output | 1 | Invalid-operation flag, qualified by `out_valid` |

## Verification
The assertions watch the strobe timing on every cycle, along with the rule that the flag never appears without a valid result. They also check that illegal codes always raise the flag, that a non-NaN double copies through, and that the single-to-half default pattern appears under default mode. Payload placement when widening and narrowing, the payload-truncated-to-zero fallback, and the polarity-swapped classification across all format pairs are shown only by the bench. The bench sweeps every code pair, both polarities and both modes over a set of edge operands.

// File: rtl/nan_conv_pkg.sv
package nan_conv_pkg;

    localparam int WORD_W  = 64;
    localparam int CANON_W = 64;
    localparam int FMT_CNT = 3;

    typedef enum logic [1:0] {
        FMT_HALF   = 2'd0,
        FMT_SINGLE = 2'd1,
        FMT_DOUBLE = 2'd2,
        FMT_BAD    = 2'd3
    } fmt_e;

    typedef struct packed {
        logic              valid;
        logic              invalid;
        logic [WORD_W-1:0] value;
    } conv_state_t;

    function automatic int fmt_exp_w(input int code);
        case (code)
            0:       return 5;
            1:       return 8;
            default: return 11;
        endcase
    endfunction

    function automatic int fmt_frac_w(input int code);
        case (code)
            0:       return 10;
            1:       return 23;
            default: return 52;
        endcase
    endfunction

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W-1:0] bits,
    input  logic                    snan_pol,
    output logic                    is_nan,
    output logic                    is_snan
);
    logic exp_ones;
    logic top_bit;
    logic rest_nz;
    logic top_set_nan;
    logic top_clr_nan;

    always_comb begin
        exp_ones    = &bits[EXP_W+FRAC_W-1:FRAC_W];
        top_bit     = bits[FRAC_W-1];
        rest_nz     = |bits[FRAC_W-2:0];
        top_set_nan = exp_ones & top_bit;
        top_clr_nan = exp_ones & ~top_bit & rest_nz;
        is_nan      = top_set_nan | top_clr_nan;
        is_snan     = snan_pol ? top_set_nan : top_clr_nan;
    end
endmodule

// File: rtl/nan_pack.sv
module nan_pack #(
    parameter int EXP_W   = 8,
    parameter int FRAC_W  = 23,
    parameter int CANON_W = 64,
    localparam int FULL_W = EXP_W + FRAC_W + 1
) (
    input  logic               sign,
    input  logic [CANON_W-1:0] canon,
    input  logic               snan_pol,
    output logic [FULL_W-1:0]  nan_word,
    output logic [FULL_W-1:0]  dflt_word,
    output logic               payload_zero
);
    logic [FRAC_W-1:0] frac;
    logic              unused_tail;

    always_comb begin
        frac         = canon[CANON_W-1 -: FRAC_W];
        unused_tail  = ^canon[CANON_W-FRAC_W-1:0];
        payload_zero = ~|frac;
        nan_word     = {sign, {EXP_W{1'b1}}, frac};
        if (snan_pol)
            dflt_word = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
        else
            dflt_word = {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    end
endmodule

// File: rtl/nan_fmt_conv.sv
module nan_fmt_conv
    import nan_conv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_value,
    input  logic [1:0]        src_fmt,
    input  logic [1:0]        dst_fmt,
    input  logic              dflt_mode,
    input  logic              snan_pol,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_value,
    output logic              out_invalid
);
    logic [FMT_CNT-1:0] nan_v;
    logic [FMT_CNT-1:0] snan_v;
    logic [FMT_CNT-1:0] zero_v;
    logic [FMT_CNT-1:0] sign_v;
    logic [CANON_W-1:0] canon_v [FMT_CNT];
    logic [WORD_W-1:0]  build_v [FMT_CNT];
    logic [WORD_W-1:0]  dflt_v  [FMT_CNT];

    logic               src_bad;
    logic               dst_bad;
    logic [1:0]         src_i;
    logic [1:0]         dst_i;
    logic [CANON_W-1:0] canon_sel;
    logic               sign_sel;

    conv_state_t state_d;
    conv_state_t state_q;

    for (genvar g = 0; g < FMT_CNT; g++) begin : g_fmt
        localparam int EW   = fmt_exp_w(g);
        localparam int FW   = fmt_frac_w(g);
        localparam int FULL = EW + FW + 1;

        logic [FULL-1:0] pack_nan;
        logic [FULL-1:0] pack_dflt;

        nan_classify #(
            .EXP_W (EW),
            .FRAC_W(FW)
        ) i_classify (
            .bits    (in_value[FULL-2:0]),
            .snan_pol(snan_pol),
            .is_nan  (nan_v[g]),
            .is_snan (snan_v[g])
        );

        assign sign_v[g]  = in_value[FULL-1];
        assign canon_v[g] = CANON_W'(in_value[FW-1:0]) << (CANON_W - FW);

        nan_pack #(
            .EXP_W  (EW),
            .FRAC_W (FW),
            .CANON_W(CANON_W)
        ) i_pack (
            .sign        (sign_sel),
            .canon       (canon_sel),
            .snan_pol    (snan_pol),
            .nan_word    (pack_nan),
            .dflt_word   (pack_dflt),
            .payload_zero(zero_v[g])
        );

        assign build_v[g] = WORD_W'(pack_nan);
        assign dflt_v[g]  = WORD_W'(pack_dflt);
    end

    always_comb begin
        src_bad   = (src_fmt == FMT_BAD);
        dst_bad   = (dst_fmt == FMT_BAD);
        src_i     = src_bad ? FMT_DOUBLE : src_fmt;
        dst_i     = dst_bad ? FMT_DOUBLE : dst_fmt;
        canon_sel = canon_v[src_i];
        sign_sel  = sign_v[src_i];

        state_d         = state_q;
        state_d.valid   = in_valid;
        state_d.invalid = 1'b0;
        if (in_valid) begin
            if (src_bad || dst_bad) begin
                state_d.value   = dflt_v[dst_i];
                state_d.invalid = 1'b1;
            end else if (!nan_v[src_i]) begin
                state_d.value   = in_value;
            end else begin
                state_d.invalid = snan_v[src_i];
                if (dflt_mode || zero_v[dst_i])
                    state_d.value = dflt_v[dst_i];
                else
                    state_d.value = build_v[dst_i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign out_valid   = state_q.valid;
    assign out_value   = state_q.value;
    assign out_invalid = state_q.invalid;
endmodule

// File: rtl/nan_conv_checks.sv
module nan_conv_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] in_value,
    input logic [1:0]  src_fmt,
    input logic [1:0]  dst_fmt,
    input logic        dflt_mode,
    input logic        snan_pol,
    input logic        out_valid,
    input logic [63:0] out_value,
    input logic        out_invalid
);
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    a_r1_flag_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> out_valid);

    a_r9_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (src_fmt == 2'd3 || dst_fmt == 2'd3)) |=> out_invalid);

    a_r7_double_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && src_fmt == 2'd2 && dst_fmt != 2'd3 && in_value[62:52] != 11'h7FF)
        |=> (out_value == $past(in_value) && !out_invalid));

    a_r6_single_to_half_default: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dflt_mode && src_fmt == 2'd1 && dst_fmt == 2'd0
         && in_value[30:23] == 8'hFF && in_value[22:0] != 23'd0)
        |=> (out_value == ($past(snan_pol) ? 64'h7DFF : 64'hFE00)));
endmodule

bind nan_fmt_conv nan_conv_checks i_checks (.*);

// File: tb/test_nan_fmt_conv.sv
`timescale 1ns/1ps
module test_nan_fmt_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_value = '0;
    logic [1:0]  src_fmt = '0;
    logic [1:0]  dst_fmt = '0;
    logic        dflt_mode = 1'b0;
    logic        snan_pol = 1'b0;
    logic        out_valid;
    logic [63:0] out_value;
    logic        out_invalid;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    nan_fmt_conv i_nan_fmt_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
        .src_fmt(src_fmt), .dst_fmt(dst_fmt), .dflt_mode(dflt_mode),
        .snan_pol(snan_pol), .out_valid(out_valid), .out_value(out_value),
        .out_invalid(out_invalid)
    );

    function automatic int ew(input int c);
        return (c == 0) ? 5 : (c == 1) ? 8 : 11;
    endfunction

    function automatic int fw(input int c);
        return (c == 0) ? 10 : (c == 1) ? 23 : 52;
    endfunction

    function automatic logic [63:0] ones(input int n);
        return (64'd1 << n) - 64'd1;
    endfunction

    // R8: default pattern computed from field widths and polarity
    function automatic logic [63:0] dflt_of(input int c, input logic pol);
        int e = ew(c);
        int f = fw(c);
        if (pol)
            return (ones(e) << f) | ones(f - 1);
        return (64'd1 << (e + f)) | (ones(e) << f) | (64'd1 << (f - 1));
    endfunction

    // reference result: bit 64 = invalid flag
    function automatic logic [64:0] ref_conv(input int s, input int d,
                                             input logic pol, input logic dm,
                                             input logic [63:0] x);
        int es = ew(s);
        int fs = fw(s);
        int ed = ew(d);
        int fd = fw(d);
        logic [63:0] ex, fr, p, dv;
        logic isn, iss, sg;
        dv = dflt_of((d == 3) ? 2 : d, pol);
        if (s == 3 || d == 3) return {1'b1, dv};
        ex  = (x >> fs) & ones(es);
        fr  = x & ones(fs);
        sg  = x[fs + es];
        isn = (ex == ones(es)) && (fr != 0);
        iss = isn && (fr[fs - 1] == pol);
        if (!isn) return {1'b0, x};
        if (dm) return {iss, dv};
        p = (fd >= fs) ? (fr << (fd - fs)) : (fr >> (fs - fd));
        if (p == 0) return {iss, dv};
        return {iss, (64'(sg) << (fd + ed)) | (ones(ed) << fd) | p};
    endfunction

    function automatic logic [63:0] make_op(input int c, input int k);
        int e = ew((c == 3) ? 2 : c);
        int f = fw((c == 3) ? 2 : c);
        logic [63:0] expf = ones(e);
        logic [63:0] fr;
        logic sg = 1'b0;
        case (k)
            0: fr = (64'd1 << (f - 1)) | 64'd1;
            1: fr = 64'd1;
            2: fr = 64'd1 << (f - 2);
            3: begin fr = 64'd1 << (f - 1); sg = 1'b1; end
            4: fr = 64'd0;
            5: begin fr = 64'd0; expf = 64'd0; end
            6: begin fr = 64'd5; expf = 64'd1; sg = 1'b1; end
            default: begin fr = ones(f); sg = 1'b1; end
        endcase
        return (64'(sg) << (f + e)) | (expf << f) | fr;
    endfunction

    task automatic check(input logic ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_one(input int s, input int d, input logic pol,
                           input logic dm, input logic [63:0] x);
        logic [64:0] r;
        string tag;
        r = ref_conv(s, d, pol, dm, x);
        @(negedge clk);
        in_valid  = 1'b1;
        in_value  = x;
        src_fmt   = 2'(s);
        dst_fmt   = 2'(d);
        snan_pol  = pol;
        dflt_mode = dm;
        @(negedge clk);
        in_valid = 1'b0;
        if (s == 3 || d == 3)            tag = "R9 value";
        else if (r[63:0] == x)           tag = "R7 R4 value";
        else if (dm)                     tag = "R6 R8 value";
        else if (r[63:0] == dflt_of(d, pol)) tag = "R5 R8 value";
        else                             tag = "R3 R4 value";
        check(out_valid === 1'b1, "R1 valid", 64'(out_valid), 64'd1);
        check(out_value === r[63:0], tag, out_value, r[63:0]);
        check(out_invalid === r[64], "R2 invalid flag", 64'(out_invalid), 64'(r[64]));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [63:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        check(out_invalid === 1'b0, "R1 reset flag", 64'(out_invalid), 64'd0);
        check(out_value === 64'd0, "R1 reset value", out_value, 64'd0);
        rst_n = 1'b1;

        for (int s = 0; s < 4; s++)
            for (int d = 0; d < 4; d++)
                for (int p = 0; p < 2; p++)
                    for (int m = 0; m < 2; m++)
                        for (int k = 0; k < 8; k++)
                            run_one(s, d, 1'(p), 1'(m), make_op(s, k));

        // R1: idle cycle drops valid and flag, holds value
        run_one(1, 0, 1'b0, 1'b0, 64'h0000_0000_7F80_0001);
        held = out_value;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 idle valid", 64'(out_valid), 64'd0);
        check(out_invalid === 1'b0, "R1 idle flag", 64'(out_invalid), 64'd0);
        check(out_value === held, "R1 idle hold", out_value, held);

        // R4: explicit widening of a half quiet NaN to double
        run_one(0, 2, 1'b0, 1'b0, 64'h0000_0000_0000_FE01);
        check(out_value === 64'hFFF8_0400_0000_0000, "R4 widen", out_value,
              64'hFFF8_0400_0000_0000);
        // R5: single signaling NaN with low payload narrowed to half
        run_one(1, 0, 1'b0, 1'b0, 64'h0000_0000_7F80_0003);
        check(out_value === 64'h0000_0000_0000_FE00, "R5 truncated", out_value, 64'hFE00);
        // R8: double default with polarity one
        run_one(0, 2, 1'b1, 1'b1, 64'h0000_0000_0000_7E00);
        check(out_value === 64'h7FF7_FFFF_FFFF_FFFF, "R8 pol1 default", out_value,
              64'h7FF7_FFFF_FFFF_FFFF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule